// File: doc/BRIEF.md
# Dual-Channel PWM with Event-Driven Output Actions

This block generates two pulse-width-modulated outputs, A and B, from one shared time-base counter. The counter runs from a divided clock and can count up, count down, count up then down, or hold. Two compare values are matched against the counter. Each output has its own table of actions, chosen per counter event: counter at zero, counter equal to compare A while counting up, and counter equal to compare B while counting up. Each action can leave the output alone, drive it low, drive it high or toggle it.

A single-cycle write port programs every setting. Compare values can take effect at once, or they can go through a shadow copy that moves into the active value only on a selected counter event. A typical use sets an output high at zero and clears it on its compare match, which gives a high time equal to the compare value in ticks and a period of the period register plus one.

Top module: `pwm_aq_top`

## Requirements
- R1: After a synchronous active-low reset both outputs are low. The counter sits at 0 in hold mode. The period register holds 999, so once counting up is enabled the counter reaches 999 and then wraps to 0.
- R2: In up mode (mode code 0) the counter advances by one on every tick. On the tick after it reaches the period register value (or anything above it) it returns to 0.
- R3: In down mode (mode code 1) the counter decrements on each tick and reloads the period value after 0. No compare action ever fires in this mode.
- R4: In up-down mode (mode code 2) the counter reverses at the period value and at 0. The waveform period is twice the period value in ticks, and compare actions fire only on matches reached while counting up.
- R5: Mode code 3 holds the counter and fires no event.
- R6: Action codes are 0 none, 1 drive low, 2 drive high and 3 toggle. Each output's action register holds the zero-event code in bits 1:0, the compare-A-up code in bits 5:4 and the compare-B-up code in bits 9:8.
- R7: With set-on-zero and clear-on-own-compare in up mode, the output is high for exactly the compare value in ticks per period. A compare value above the period register keeps the output high.
- R8: When several events occur on one tick, the non-none action of the highest-ranked event applies. The ranking from lowest to highest is zero, compare A, compare B. As a result, compare 0 with set-on-zero and clear-on-compare stays low.
- R9: Compare-control bit 4 (A) and bit 6 (B) enable shadowing. With the bit at 0, a compare write changes the active value on the same clock edge. With the bit at 1, the write goes to the shadow copy only.
- R10: Compare-control bits 1:0 (A) and 3:2 (B) choose when the shadow copy moves to the active value: 0 at a zero event, 1 at a period-match event, 2 at either, 3 never.
- R11: The control register holds the mode in bits 1:0, a coarse divider c in bits 4:2 and a fine divider f in bits 7:5. One tick is (2^c) x (f = 0 ? 1 : 2f) clocks, so c = f = 0 gives a tick on every clock.
- R12: Write addresses: 0 control, 1 period, 2 compare control, 3 compare A, 4 compare B, 5 output-A actions, 6 output-B actions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| cnt_o | output | CNT_W | Current time-base counter value |

## Verification
The main function is tried with a set of programmings, each measured as the high count of both outputs over one full output period in steady state. A plain up-mode duty pair checks that each output follows its own compare. Compare values of 0 and above the period separate the compare-beats-zero rule from simple wrap behaviour. Two divider settings separate the coarse and fine prescaler terms. Up-down mode shows that a match counts only while rising, because counting both crossings would give a different high time. Down mode with a toggle-on-zero shows that compare actions are silent there. Equal compares on both channels with opposite actions show that B outranks A. The shadow tests write a new compare in mid-period and sample at a fixed counter value before and after the next wrap, which separates immediate, event-loaded and never-loaded updates.

// File: rtl/pwm_aq_pkg.sv
// Shared types for the dual-channel PWM.
// Assumes two output channels and a 3-bit register address space.
package pwm_aq_pkg;

    localparam int NCH    = 2;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] REG_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] REG_PRD  = 3'd1;
    localparam logic [ADDR_W-1:0] REG_CCTL = 3'd2;
    localparam logic [ADDR_W-1:0] REG_CMP0 = 3'd3;
    localparam logic [ADDR_W-1:0] REG_ACT0 = 3'd5;

    typedef enum logic [1:0] {
        CM_UP     = 2'd0,
        CM_DOWN   = 2'd1,
        CM_UPDOWN = 2'd2,
        CM_HOLD   = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_LOW  = 2'd1,
        ACT_HIGH = 2'd2,
        ACT_FLIP = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        LD_ZERO  = 2'd0,
        LD_PRD   = 2'd1,
        LD_BOTH  = 2'd2,
        LD_NEVER = 2'd3
    } load_e;

    typedef struct packed {
        act_e on_cbu;
        act_e on_cau;
        act_e on_zero;
    } act_cfg_t;

endpackage

// File: rtl/pwm_aq_regs.sv
// Configuration registers behind the write port.
// Decodes the control, period, compare-control and action registers and
// produces one write strobe per compare register. Assumes DATA_W >= CNT_W,
// DATA_W >= 10 and DATA_W >= 2 + CDIV_W + FDIV_W.
module pwm_aq_regs
    import pwm_aq_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int CNT_W   = 16,
    parameter int CDIV_W  = 3,
    parameter int FDIV_W  = 3,
    parameter int PRD_RST = 999
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    output cnt_mode_e                  run_mode,
    output logic [CDIV_W-1:0]          cdiv,
    output logic [FDIV_W-1:0]          fdiv,
    output logic [CNT_W-1:0]           prd,
    output logic [NCH-1:0]             sh_en,
    output load_e [NCH-1:0]            ld_sel,
    output act_cfg_t [NCH-1:0]         act_cfg,
    output logic [NCH-1:0]             cmp_wr,
    output logic [CNT_W-1:0]           cmp_wdata
);

    localparam int CD_LSB = 2;
    localparam int FD_LSB = CD_LSB + CDIV_W;
    localparam int CTRL_W = FD_LSB + FDIV_W;
    localparam int SH_LSB = 2 * NCH;

    logic [CTRL_W-1:0]   ctrl_q;
    logic [CNT_W-1:0]    prd_q;
    logic [2*NCH-1:0]    ld_q;
    logic [NCH-1:0]      sh_q;
    act_cfg_t [NCH-1:0]  act_q;

    // Control register: mode and divider fields; resets to hold mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= {{(CTRL_W-2){1'b0}}, 2'b11};
        else if (wr_en && wr_addr == REG_CTRL)
            ctrl_q <= wr_data[CTRL_W-1:0];
    end

    // Period register: holds the period minus one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prd_q <= CNT_W'(PRD_RST);
        else if (wr_en && wr_addr == REG_PRD)
            prd_q <= wr_data[CNT_W-1:0];
    end

    // Compare-control load-mode fields.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ld_q <= '0;
        else if (wr_en && wr_addr == REG_CCTL)
            ld_q <= wr_data[2*NCH-1:0];
    end

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            // Shadow-enable bit for channel i, at bit 4 + 2i.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    sh_q[i] <= 1'b0;
                else if (wr_en && wr_addr == REG_CCTL)
                    sh_q[i] <= wr_data[SH_LSB + 2*i];
            end

            // Action register for output i.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    act_q[i] <= '0;
                else if (wr_en && wr_addr == (REG_ACT0 + ADDR_W'(i)))
                    act_q[i] <= '{on_cbu:  act_e'(wr_data[9:8]),
                                  on_cau:  act_e'(wr_data[5:4]),
                                  on_zero: act_e'(wr_data[1:0])};
            end

            assign sh_en[i]   = sh_q[i];
            assign ld_sel[i]  = load_e'(ld_q[2*i +: 2]);
            assign act_cfg[i] = act_q[i];
            assign cmp_wr[i]  = wr_en && (wr_addr == (REG_CMP0 + ADDR_W'(i)));
        end
    endgenerate

    assign run_mode  = cnt_mode_e'(ctrl_q[1:0]);
    assign cdiv      = ctrl_q[CD_LSB +: CDIV_W];
    assign fdiv      = ctrl_q[FD_LSB +: FDIV_W];
    assign prd       = prd_q;
    assign cmp_wdata = wr_data[CNT_W-1:0];

endmodule

// File: rtl/pwm_aq_prescale.sv
// Tick generator: one tick every (2^cdiv) * (fdiv == 0 ? 1 : 2*fdiv) clocks.
// Assumes the divider may change at any time; an out-of-range count
// simply produces a tick on the next clock.
module pwm_aq_prescale
    import pwm_aq_pkg::*;
#(
    parameter int CDIV_W = 3,
    parameter int FDIV_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cnt_mode_e         run_mode,
    input  logic [CDIV_W-1:0] cdiv,
    input  logic [FDIV_W-1:0] fdiv,
    output logic              tick
);

    localparam int DIV_W = (1 << CDIV_W) + FDIV_W + 1;

    logic [DIV_W-1:0] fine_f;
    logic [DIV_W-1:0] ratio;
    logic [DIV_W-1:0] last;
    logic [DIV_W-1:0] pre_q;
    logic             running;

    // Divide ratio from the two divider fields.
    always_comb begin
        fine_f = (fdiv == '0) ? DIV_W'(1) : DIV_W'({fdiv, 1'b0});
        ratio  = fine_f << cdiv;
        last   = ratio - 1'b1;
    end

    assign running = (run_mode != CM_HOLD);
    assign tick    = running && (pre_q >= last);

    // Prescale counter; cleared on each tick and while held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (!running || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

endmodule

// File: rtl/pwm_aq_timebase.sv
// Time-base counter with up, down, up-down and hold modes.
// Events are flagged for the counter value present on a tick; the counter
// and all event-driven state then update on that same clock edge.
module pwm_aq_timebase
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  cnt_mode_e        run_mode,
    input  logic [CNT_W-1:0] prd,
    output logic [CNT_W-1:0] cnt,
    output logic             count_up,
    output logic             evt_zero,
    output logic             evt_prd
);

    logic [CNT_W-1:0] cnt_q;
    logic             dir_up_q;

    assign cnt      = cnt_q;
    assign count_up = (run_mode == CM_UP) || (run_mode == CM_UPDOWN && dir_up_q);
    assign evt_zero = tick && (cnt_q == '0);
    assign evt_prd  = tick && (cnt_q == prd);

    // Counter and direction update, one step per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            dir_up_q <= 1'b1;
        end else if (tick) begin
            unique case (run_mode)
                CM_UP: begin
                    dir_up_q <= 1'b1;
                    cnt_q    <= (cnt_q >= prd) ? '0 : cnt_q + 1'b1;
                end
                CM_DOWN: begin
                    dir_up_q <= 1'b1;
                    cnt_q    <= (cnt_q == '0) ? prd : cnt_q - 1'b1;
                end
                CM_UPDOWN: begin
                    if (dir_up_q) begin
                        if (cnt_q >= prd) begin
                            dir_up_q <= 1'b0;
                            cnt_q    <= (cnt_q == '0) ? '0 : cnt_q - 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end else begin
                        if (cnt_q == '0) begin
                            dir_up_q <= 1'b1;
                            cnt_q    <= (prd == '0) ? '0 : CNT_W'(1);
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
                default: begin
                    cnt_q <= cnt_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/pwm_aq_cmp.sv
// One compare channel: active value, optional shadow copy, and match flag.
// Assumes a write while shadowing goes only to the shadow copy; a load on
// the same edge moves the previous shadow value.
module pwm_aq_cmp
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             sh_en,
    input  load_e            ld_sel,
    input  logic             tick,
    input  logic             count_up,
    input  logic             evt_zero,
    input  logic             evt_prd,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] active,
    output logic             hit
);

    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] active_q;
    logic             ld_now;

    // Shadow transfer condition from the selected load event.
    always_comb begin
        unique case (ld_sel)
            LD_ZERO:  ld_now = evt_zero;
            LD_PRD:   ld_now = evt_prd;
            LD_BOTH:  ld_now = evt_zero || evt_prd;
            default:  ld_now = 1'b0;
        endcase
        ld_now = ld_now && sh_en;
    end

    // Shadow copy captures writes only while shadowing is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (wr && sh_en)
            shadow_q <= wdata;
    end

    // Active value: direct write or shadow transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= '0;
        else if (wr && !sh_en)
            active_q <= wdata;
        else if (ld_now)
            active_q <= shadow_q;
    end

    assign active = active_q;
    assign hit    = tick && count_up && (cnt == active_q);

endmodule

// File: rtl/pwm_aq_action.sv
// Output driver for one channel: picks one action per tick and applies it.
// Ranking, lowest to highest: zero event, compare A, compare B. An event
// whose code is "none" does not mask a lower-ranked one.
module pwm_aq_action
    import pwm_aq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  act_cfg_t cfg,
    input  logic     evt_zero,
    input  logic     hit_a,
    input  logic     hit_b,
    output logic     pwm
);

    act_e sel;
    logic pwm_q;

    // Select the winning action for this tick.
    always_comb begin
        sel = ACT_NONE;
        if (evt_zero && cfg.on_zero != ACT_NONE) sel = cfg.on_zero;
        if (hit_a && cfg.on_cau != ACT_NONE)     sel = cfg.on_cau;
        if (hit_b && cfg.on_cbu != ACT_NONE)     sel = cfg.on_cbu;
    end

    // Apply the selected action to the output register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwm_q <= 1'b0;
        else begin
            unique case (sel)
                ACT_LOW:  pwm_q <= 1'b0;
                ACT_HIGH: pwm_q <= 1'b1;
                ACT_FLIP: pwm_q <= ~pwm_q;
                default:  pwm_q <= pwm_q;
            endcase
        end
    end

    assign pwm = pwm_q;

endmodule

// File: rtl/pwm_aq_top.sv
// Dual-channel PWM top: registers, prescaler, time base, two compare
// channels and two output action units. Assumes a single clock domain and
// a synchronous active-low reset.
module pwm_aq_top
    import pwm_aq_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int CNT_W   = 16,
    parameter int CDIV_W  = 3,
    parameter int FDIV_W  = 3,
    parameter int PRD_RST = 999
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_a,
    output logic              pwm_b,
    output logic [CNT_W-1:0]  cnt_o
);

    cnt_mode_e                 run_mode;
    logic [CDIV_W-1:0]         cdiv;
    logic [FDIV_W-1:0]         fdiv;
    logic [CNT_W-1:0]          prd_val;
    logic [NCH-1:0]            sh_en;
    load_e [NCH-1:0]           ld_sel;
    act_cfg_t [NCH-1:0]        act_cfg;
    logic [NCH-1:0]            cmp_wr;
    logic [CNT_W-1:0]          cmp_wdata;
    logic                      tb_tick;
    logic [CNT_W-1:0]          cnt_val;
    logic                      count_up;
    logic                      evt_zero;
    logic                      evt_prd;
    logic [NCH-1:0][CNT_W-1:0] cmp_act;
    logic [NCH-1:0]            cmp_hit;
    logic [NCH-1:0]            pwm_q;

    pwm_aq_regs #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .CDIV_W (CDIV_W),
        .FDIV_W (FDIV_W),
        .PRD_RST(PRD_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .run_mode (run_mode),
        .cdiv     (cdiv),
        .fdiv     (fdiv),
        .prd      (prd_val),
        .sh_en    (sh_en),
        .ld_sel   (ld_sel),
        .act_cfg  (act_cfg),
        .cmp_wr   (cmp_wr),
        .cmp_wdata(cmp_wdata)
    );

    pwm_aq_prescale #(
        .CDIV_W(CDIV_W),
        .FDIV_W(FDIV_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_mode(run_mode),
        .cdiv    (cdiv),
        .fdiv    (fdiv),
        .tick    (tb_tick)
    );

    pwm_aq_timebase #(
        .CNT_W(CNT_W)
    ) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tb_tick),
        .run_mode(run_mode),
        .prd     (prd_val),
        .cnt     (cnt_val),
        .count_up(count_up),
        .evt_zero(evt_zero),
        .evt_prd (evt_prd)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_cmp
            pwm_aq_cmp #(
                .CNT_W(CNT_W)
            ) u_cmp (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr      (cmp_wr[i]),
                .wdata   (cmp_wdata),
                .sh_en   (sh_en[i]),
                .ld_sel  (ld_sel[i]),
                .tick    (tb_tick),
                .count_up(count_up),
                .evt_zero(evt_zero),
                .evt_prd (evt_prd),
                .cnt     (cnt_val),
                .active  (cmp_act[i]),
                .hit     (cmp_hit[i])
            );
        end

        for (genvar i = 0; i < NCH; i++) begin : g_out
            pwm_aq_action u_act (
                .clk     (clk),
                .rst_n   (rst_n),
                .cfg     (act_cfg[i]),
                .evt_zero(evt_zero),
                .hit_a   (cmp_hit[0]),
                .hit_b   (cmp_hit[1]),
                .pwm     (pwm_q[i])
            );
        end
    endgenerate

    assign pwm_a = pwm_q[0];
    assign pwm_b = pwm_q[1];
    assign cnt_o = cnt_val;

endmodule

// File: rtl/pwm_aq_chk.sv
// Property checker for the dual-channel PWM, bound into the top module.
module pwm_aq_chk
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  cnt_mode_e                 mode,
    input  logic                      tick,
    input  logic [CNT_W-1:0]          prd,
    input  logic [CNT_W-1:0]          cnt,
    input  logic                      count_up,
    input  logic                      evt_zero,
    input  logic [NCH-1:0]            hit,
    input  act_cfg_t                  act0,
    input  logic [NCH-1:0]            sh_en,
    input  load_e [NCH-1:0]           ld_sel,
    input  logic [NCH-1:0][CNT_W-1:0] cmp_act,
    input  logic [NCH-1:0]            pwm
);

    // R5: hold mode leaves the counter where it is.
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_HOLD) |=> $stable(cnt));

    // R2: up mode wraps to zero after the period value.
    a_r2_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_UP && tick && cnt >= prd) |=> (cnt == '0));

    // R2: up mode steps by one below the period value.
    a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_UP && tick && cnt < prd) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R11: nothing moves between ticks.
    a_r11_no_tick_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick) |=> ($stable(cnt) && $stable(pwm)));

    // R3: no compare match while counting down.
    a_r3_down_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_DOWN) |-> (hit == '0));

    // R4: up-down reverses at the period value.
    a_r4_reverse: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_UPDOWN && tick && count_up && cnt >= prd && cnt != '0)
        |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

    // R8: a clear on compare A beats the zero action on output A.
    a_r8_cmp_beats_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_zero && hit[0] && !hit[1] && act0.on_cau == ACT_LOW) |=> !pwm[0]);

    // R10: a never-load shadowed compare keeps its active value.
    a_r10_frozen_active: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_en[0] && ld_sel[0] == LD_NEVER) |=> $stable(cmp_act[0]));

endmodule

bind pwm_aq_top pwm_aq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (run_mode),
    .tick    (tb_tick),
    .prd     (prd_val),
    .cnt     (cnt_val),
    .count_up(count_up),
    .evt_zero(evt_zero),
    .hit     (cmp_hit),
    .act0    (act_cfg[0]),
    .sh_en   (sh_en),
    .ld_sel  (ld_sel),
    .cmp_act (cmp_act),
    .pwm     (pwm_q)
);

// File: tb/tb_pwm_aq_top.sv
module tb_pwm_aq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_a;
    logic        pwm_b;
    logic [15:0] cnt_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    pwm_aq_top dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .pwm_a  (pwm_a),
        .pwm_b  (pwm_b),
        .cnt_o  (cnt_o)
    );

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [15:0] prd;
        logic [15:0] ca;
        logic [15:0] cb;
        logic [15:0] aa;
        logic [15:0] ab;
        logic [15:0] win;
        logic [15:0] ea;
        logic [15:0] eb;
    } vec_t;

    localparam int NV = 7;
    // ctrl, period, cmpA, cmpB, actA, actB, window, expected high A, B
    localparam vec_t VECS [NV] = '{
        '{8'h00, 16'd9, 16'd3, 16'd7,  16'h0012, 16'h0102, 16'd10, 16'd3,  16'd7},
        '{8'h00, 16'd9, 16'd0, 16'd10, 16'h0012, 16'h0102, 16'd10, 16'd0,  16'd10},
        '{8'h04, 16'd4, 16'd2, 16'd4,  16'h0012, 16'h0102, 16'd10, 16'd4,  16'd8},
        '{8'h24, 16'd3, 16'd1, 16'd2,  16'h0012, 16'h0102, 16'd16, 16'd4,  16'd8},
        '{8'h02, 16'd8, 16'd3, 16'd5,  16'h0021, 16'h0102, 16'd16, 16'd13, 16'd5},
        '{8'h01, 16'd9, 16'd3, 16'd4,  16'h0003, 16'h0102, 16'd20, 16'd10, 16'd20},
        '{8'h00, 16'd9, 16'd5, 16'd5,  16'h0120, 16'h0210, 16'd10, 16'd0,  16'd10}
    };
    localparam string TAGS [NV] = '{
        "R7 R12 up duty",
        "R8 R7 compare 0 and above period",
        "R11 coarse divide",
        "R11 coarse and fine divide",
        "R4 up-down count-up matches",
        "R3 R6 down mode toggle on zero",
        "R8 R6 compare B over compare A"
    };

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL [%s] actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_cnt(input logic [15:0] k);
        while (cnt_o !== k) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Shadow test: write a new compare mid-period, sample before and after a wrap.
    task automatic shadow_case(input string tag, input logic [15:0] cctl, input int ch,
                               input int exp_before, input int exp_after);
        do_reset();
        wr(3'd1, 16'd9);
        wr(3'd5, 16'h0012);
        wr(3'd6, 16'h0102);
        wr(3'd3, 16'd3);
        wr(3'd4, 16'd3);
        wr(3'd2, cctl);
        wr(3'd0, 16'h0000);
        repeat (25) @(negedge clk);
        wait_cnt(16'd1);
        wr((ch == 0) ? 3'd3 : 3'd4, (ch == 0) ? 16'd6 : 16'd7);
        wait_cnt(16'd5);
        check({tag, " before wrap"}, (ch == 0) ? int'(pwm_a) : int'(pwm_b), exp_before);
        wait_cnt(16'd0);
        wait_cnt(16'd5);
        wait_cnt(16'd0);
        wait_cnt(16'd5);
        check({tag, " after wrap"}, (ch == 0) ? int'(pwm_a) : int'(pwm_b), exp_after);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL [watchdog] actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int ha;
        int hb;
        int mx;
        logic seen_wrap;
        logic [15:0] held;

        // R1: reset state.
        do_reset();
        @(negedge clk);
        check("R1 outputs low after reset", int'({pwm_a, pwm_b}), 0);
        check("R1 counter zero after reset", int'(cnt_o), 0);
        // R5: counter held in reset mode.
        repeat (20) @(negedge clk);
        check("R5 counter frozen out of reset", int'(cnt_o), 0);

        // R1 R2: default period 999 in up mode.
        wr(3'd0, 16'h0000);
        mx = 0;
        seen_wrap = 1'b0;
        repeat (1100) begin
            @(negedge clk);
            if (int'(cnt_o) > mx) mx = int'(cnt_o);
            if (mx == 999 && cnt_o == 16'd0) seen_wrap = 1'b1;
        end
        check("R1 R2 default period top value", mx, 999);
        check("R2 wrap to zero after period", int'(seen_wrap), 1);

        // R5: hold while running.
        wr(3'd0, 16'h0003);
        held = cnt_o;
        repeat (10) @(negedge clk);
        check("R5 hold mid-run", int'(cnt_o), int'(held));

        // Vector table walk.
        for (int v = 0; v < NV; v++) begin
            do_reset();
            wr(3'd1, VECS[v].prd);
            wr(3'd3, VECS[v].ca);
            wr(3'd4, VECS[v].cb);
            wr(3'd5, VECS[v].aa);
            wr(3'd6, VECS[v].ab);
            wr(3'd0, {8'h00, VECS[v].ctrl});
            repeat (2 * int'(VECS[v].win)) @(negedge clk);
            ha = 0;
            hb = 0;
            repeat (int'(VECS[v].win)) begin
                @(negedge clk);
                ha += int'(pwm_a);
                hb += int'(pwm_b);
            end
            check({TAGS[v], " high count A"}, ha, int'(VECS[v].ea));
            check({TAGS[v], " high count B"}, hb, int'(VECS[v].eb));
        end

        // R9 R10: compare update timing.
        shadow_case("R9 immediate write",          16'h0000, 0, 1, 1);
        shadow_case("R10 R9 shadow load at zero",   16'h0010, 0, 0, 1);
        shadow_case("R10 shadow load at period",    16'h0011, 0, 0, 1);
        shadow_case("R10 shadow load at either",    16'h0012, 0, 0, 1);
        shadow_case("R10 shadow never loads",       16'h0013, 0, 0, 0);
        shadow_case("R9 R10 channel B bit 6 never", 16'h004C, 1, 0, 0);

        finish_run();
    end

endmodule